// File: doc/BRIEF.md
# Bus Address Match Comparator

This block provides three hardware breakpoint channels that watch a processor's system bus. Each channel compares every bus cycle against a programmed target and raises a one-cycle match pulse on its own output line. Debug logic downstream, such as a trigger sequencer or a trace controller, consumes these pulses.

The two full channels (A, B) can require an access direction, an access size and a data value. The reduced channel (C) can require only the address and the direction. Any channel can be switched from forced matching to tagged matching:

- In forced mode, a hit is taken when the target address is on the bus. For an opcode this is at fetch time.
- In tagged mode, the channel ignores the bus. It reports only the execute indication that an external opcode tracker gives for that channel.

Address compare is strict equality, with no odd/even adjustment. A word access that starts one byte below the target therefore does not hit. Software loads the channel settings through a small synchronous write port.

Top module: `bus_match_unit`

## Requirements
- R1: While reset is asserted, and after it is released, every channel is disabled and `match_o` is all zero.
- R2: A forced channel hits only when `bus_addr_i` is exactly equal to its programmed address. A word access at target-1 does not hit.
- R3: Direction qualification uses ctrl bit 2 (enable) and ctrl bit 3 (1 = reads only, 0 = writes only). With the enable at 0, reads and writes both hit. `bus_rd_i` = 1 marks a read.
- R4: On channels A and B, ctrl bit 4 enables size qualification and ctrl bit 5 selects word (1) or byte (0). With bit 4 at 0, either size hits. `bus_word_i` = 1 marks a word access.
- R5: On channels A and B, ctrl bit 6 requires `bus_data_i` to equal the programmed data over the full data width.
- R6: Channel C ignores ctrl bits 4, 5 and 6 and the bus data. It qualifies on address and direction only.
- R7: With ctrl bit 1 (tag) set, a channel's output equals its `tag_exec_i` bit from the previous cycle. Address, direction, size, data and `bus_valid_i` have no effect.
- R8: A forced channel never hits in a cycle where `bus_valid_i` is low.
- R9: A channel whose ctrl bit 0 (enable) is 0 never asserts its match output.
- R10: Matches are registered. A qualifying cycle gives a pulse on the next clock only, and nothing is held. `match_o` bits 0, 1 and 2 belong to channels A, B and C, and they can assert together.
- R11: A write with `cfg_we_i` high loads ctrl, address and data into the channel that `cfg_sel_i` names (0 = A, 1 = B, 2 = C). The new settings apply from the next cycle. A select value of 3 changes no channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Settings write strobe |
| cfg_sel_i | input | 2 | Channel select for the write |
| cfg_ctrl_i | input | 7 | Control bits: en, tag, dir_en, dir_rd, size_en, size_word, data_en (bit 0 up) |
| cfg_addr_i | input | 16 | Target address |
| cfg_data_i | input | 16 | Target data |
| bus_valid_i | input | 1 | Bus cycle valid |
| bus_rd_i | input | 1 | 1 = read, 0 = write |
| bus_word_i | input | 1 | 1 = word, 0 = byte |
| bus_addr_i | input | 16 | Bus address |
| bus_data_i | input | 16 | Bus data |
| tag_exec_i | input | 3 | Per-channel tagged opcode reached execution |
| match_o | output | 3 | Per-channel match pulse (bit 0 = A) |

## Verification
A stored setting that is corrupted or written to the wrong channel shows at the ports on the first bus cycle that probes that setting. The match for that cycle appears exactly one clock later: a pulse that is missing, or a pulse on the wrong bit. For this reason each scenario first programs a channel and then at once drives bus cycles that differ from the target in a single qualifier. A wrong select decode or a wrong qualifier mask then gives a wrong bit in the very next sample.

// File: rtl/bus_match_pkg.sv
package bus_match_pkg;
  parameter int unsigned ADDR_W  = 16;
  parameter int unsigned DATA_W  = 16;
  parameter int unsigned NUM_CH  = 3;
  parameter int unsigned QUAL_CH = 2;   // leading channels with size/data qualifiers
  parameter int unsigned CTRL_W  = 7;
  localparam int unsigned SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  // ctrl bit positions
  localparam int unsigned C_EN    = 0;
  localparam int unsigned C_TAG   = 1;
  localparam int unsigned C_DIRE  = 2;
  localparam int unsigned C_DIRR  = 3;
  localparam int unsigned C_SZE   = 4;
  localparam int unsigned C_SZW   = 5;
  localparam int unsigned C_DATE  = 6;

  typedef struct packed {
    logic              en;
    logic              tag;
    logic              dir_en;
    logic              dir_rd;
    logic              size_en;
    logic              size_word;
    logic              data_en;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } ch_cfg_t;
endpackage

// File: rtl/match_cfg_bank.sv
module match_cfg_bank
  import bus_match_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output ch_cfg_t           cfg_o [NUM_CH]
);
  ch_cfg_t wr_val;

  always_comb begin
    wr_val.en        = ctrl_i[C_EN];
    wr_val.tag       = ctrl_i[C_TAG];
    wr_val.dir_en    = ctrl_i[C_DIRE];
    wr_val.dir_rd    = ctrl_i[C_DIRR];
    wr_val.size_en   = ctrl_i[C_SZE];
    wr_val.size_word = ctrl_i[C_SZW];
    wr_val.data_en   = ctrl_i[C_DATE];
    wr_val.addr      = addr_i;
    wr_val.data      = data_i;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit_sel;
    assign hit_sel = we_i && (sel_i == SEL_W'(c));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cfg_o[c] <= '0;
      else if (hit_sel) cfg_o[c] <= wr_val;
    end
  end
endmodule

// File: rtl/match_chan.sv
module match_chan
  import bus_match_pkg::*;
#(
  parameter bit HAS_QUAL = 1'b1
) (
  input  ch_cfg_t           cfg_i,
  input  logic              bus_valid_i,
  input  logic              bus_rd_i,
  input  logic              bus_word_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              tag_exec_i,
  output logic              hit_o
);
  logic addr_ok, dir_ok, size_ok, data_ok, forced_hit;

  // exact compare: no even/odd folding, overlapping words never hit
  assign addr_ok = (bus_addr_i == cfg_i.addr);
  assign dir_ok  = !cfg_i.dir_en || (bus_rd_i == cfg_i.dir_rd);

  if (HAS_QUAL) begin : g_full
    assign size_ok = !cfg_i.size_en || (bus_word_i == cfg_i.size_word);
    assign data_ok = !cfg_i.data_en || (bus_data_i == cfg_i.data);
  end else begin : g_lite
    logic unused_qual;
    assign unused_qual = ^{cfg_i.size_en, cfg_i.size_word, cfg_i.data_en,
                           cfg_i.data, bus_word_i, bus_data_i};
    assign size_ok = 1'b1;
    assign data_ok = 1'b1;
  end

  assign forced_hit = bus_valid_i && addr_ok && dir_ok && size_ok && data_ok;
  // tagged: all bus qualifiers masked, execution indication decides
  assign hit_o = cfg_i.en && (cfg_i.tag ? tag_exec_i : forced_hit);
endmodule

// File: rtl/bus_match_unit.sv
module bus_match_unit
  import bus_match_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic [CTRL_W-1:0] cfg_ctrl_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  input  logic              bus_valid_i,
  input  logic              bus_rd_i,
  input  logic              bus_word_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic [NUM_CH-1:0] tag_exec_i,
  output logic [NUM_CH-1:0] match_o
);
  ch_cfg_t           cfg_q [NUM_CH];
  logic [NUM_CH-1:0] hit_d;
  logic [NUM_CH-1:0] match_q;

  match_cfg_bank u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .sel_i  (cfg_sel_i),
    .ctrl_i (cfg_ctrl_i),
    .addr_i (cfg_addr_i),
    .data_i (cfg_data_i),
    .cfg_o  (cfg_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    match_chan #(.HAS_QUAL(c < QUAL_CH)) u_chan (
      .cfg_i       (cfg_q[c]),
      .bus_valid_i (bus_valid_i),
      .bus_rd_i    (bus_rd_i),
      .bus_word_i  (bus_word_i),
      .bus_addr_i  (bus_addr_i),
      .bus_data_i  (bus_data_i),
      .tag_exec_i  (tag_exec_i[c]),
      .hit_o       (hit_d[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= '0;
    else         match_q <= hit_d;
  end

  assign match_o = match_q;
endmodule

// File: rtl/bus_match_chk.sv
module bus_match_chk
  import bus_match_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input ch_cfg_t           cfg_q [NUM_CH],
  input logic              bus_valid_i,
  input logic              bus_rd_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [NUM_CH-1:0] tag_exec_i,
  input logic [NUM_CH-1:0] match_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_disabled_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_q[c].en |=> !match_o[c]);

    assert_tag_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q[c].en && cfg_q[c].tag) |=> (match_o[c] == $past(tag_exec_i[c])));

    assert_no_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q[c].en && !cfg_q[c].tag && !bus_valid_i) |=> !match_o[c]);

    assert_addr_exact_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q[c].en && !cfg_q[c].tag && (bus_addr_i != cfg_q[c].addr)) |=> !match_o[c]);

    assert_dir_block_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q[c].en && !cfg_q[c].tag && cfg_q[c].dir_en && (bus_rd_i != cfg_q[c].dir_rd))
      |=> !match_o[c]);

    if (c >= QUAL_CH) begin : g_lite
      assert_lite_hit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_q[c].en && !cfg_q[c].tag && bus_valid_i && (bus_addr_i == cfg_q[c].addr) &&
         (!cfg_q[c].dir_en || (bus_rd_i == cfg_q[c].dir_rd))) |=> match_o[c]);
    end
  end
endmodule

bind bus_match_unit bus_match_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_q       (cfg_q),
  .bus_valid_i (bus_valid_i),
  .bus_rd_i    (bus_rd_i),
  .bus_addr_i  (bus_addr_i),
  .tag_exec_i  (tag_exec_i),
  .match_o     (match_o)
);

// File: tb/sim_bus_match_unit.sv
`timescale 1ns/1ps
module sim_bus_match_unit;
  localparam logic [6:0] K_EN = 7'h01, K_TAG = 7'h02, K_DIRE = 7'h04, K_DIRR = 7'h08,
                         K_SZE = 7'h10, K_SZW = 7'h20, K_DATE = 7'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [6:0]  cfg_ctrl = '0;
  logic [15:0] cfg_addr = '0, cfg_data = '0;
  logic        bus_valid = 1'b0, bus_rd = 1'b0, bus_word = 1'b0;
  logic [15:0] bus_addr = '0, bus_data = '0;
  logic [2:0]  tag_exec = '0;
  logic [2:0]  match;
  logic [2:0]  got;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  bus_match_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_ctrl_i(cfg_ctrl), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
    .bus_valid_i(bus_valid), .bus_rd_i(bus_rd), .bus_word_i(bus_word),
    .bus_addr_i(bus_addr), .bus_data_i(bus_data), .tag_exec_i(tag_exec),
    .match_o(match)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [1:0] sel, input logic [6:0] ctrl,
                        input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_ctrl = ctrl; cfg_addr = a; cfg_data = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // one bus cycle; got holds match_o one clock later
  task automatic cyc(input logic v, input logic rd, input logic wd,
                     input logic [15:0] a, input logic [15:0] d, input logic [2:0] tg);
    @(negedge clk);
    bus_valid = v; bus_rd = rd; bus_word = wd; bus_addr = a; bus_data = d; tag_exec = tg;
    @(posedge clk); #1;
    got = match;
    bus_valid = 1'b0; tag_exec = '0;
  endtask

  task automatic clear_all();
    for (int c = 0; c < 3; c++) wr_cfg(2'(c), 7'h00, 16'h0, 16'h0);
  endtask

  task automatic t_reset();
    check("R1 reset", match, 3'b000);
    cyc(1, 1, 0, 16'h0000, 16'h0, 3'b000);
    check("R1 disabled after reset", got, 3'b000);
  endtask

  task automatic t_addr();
    wr_cfg(0, K_EN, 16'h1234, 16'h0);
    cyc(1, 1, 0, 16'h1234, 16'h0, 0); check("R2 exact hit", got, 3'b001);
    cyc(1, 1, 0, 16'h1235, 16'h0, 0); check("R2 off by one", got, 3'b000);
    cyc(1, 1, 1, 16'h1233, 16'h0, 0); check("R2 overlapping word", got, 3'b000);
    @(negedge clk); #1; check("R10 pulse not held", match, 3'b000);
    clear_all();
  endtask

  task automatic t_dir();
    wr_cfg(1, K_EN | K_DIRE | K_DIRR, 16'h2000, 16'h0);
    cyc(1, 1, 0, 16'h2000, 16'h0, 0); check("R3 read-only read", got, 3'b010);
    cyc(1, 0, 0, 16'h2000, 16'h0, 0); check("R3 read-only write", got, 3'b000);
    wr_cfg(1, K_EN | K_DIRE, 16'h2000, 16'h0);
    cyc(1, 0, 0, 16'h2000, 16'h0, 0); check("R3 write-only write", got, 3'b010);
    cyc(1, 1, 0, 16'h2000, 16'h0, 0); check("R3 write-only read", got, 3'b000);
    wr_cfg(1, K_EN | K_DIRR, 16'h2000, 16'h0);
    cyc(1, 0, 0, 16'h2000, 16'h0, 0); check("R3 dir off write", got, 3'b010);
    cyc(1, 1, 0, 16'h2000, 16'h0, 0); check("R3 dir off read", got, 3'b010);
    clear_all();
  endtask

  task automatic t_size_data();
    wr_cfg(0, K_EN | K_SZE | K_SZW, 16'h4000, 16'h0);
    cyc(1, 1, 1, 16'h4000, 16'h0, 0); check("R4 word req word", got, 3'b001);
    cyc(1, 1, 0, 16'h4000, 16'h0, 0); check("R4 word req byte", got, 3'b000);
    wr_cfg(0, K_EN | K_SZE, 16'h4000, 16'h0);
    cyc(1, 1, 0, 16'h4000, 16'h0, 0); check("R4 byte req byte", got, 3'b001);
    cyc(1, 1, 1, 16'h4000, 16'h0, 0); check("R4 byte req word", got, 3'b000);
    wr_cfg(0, K_EN | K_DATE, 16'h4000, 16'hBEEF);
    cyc(1, 0, 1, 16'h4000, 16'hBEEF, 0); check("R5 data equal", got, 3'b001);
    cyc(1, 0, 1, 16'h4000, 16'hBEEE, 0); check("R5 data differs", got, 3'b000);
    clear_all();
  endtask

  task automatic t_chan_c();
    wr_cfg(2, K_EN | K_SZE | K_SZW | K_DATE, 16'h5000, 16'h1111);
    cyc(1, 1, 0, 16'h5000, 16'h2222, 0); check("R6 C ignores size/data", got, 3'b100);
    cyc(1, 1, 0, 16'h5001, 16'h1111, 0); check("R6 C address", got, 3'b000);
    clear_all();
  endtask

  task automatic t_tag();
    wr_cfg(0, K_EN | K_TAG | K_DIRE | K_SZE | K_DATE, 16'h1234, 16'h9999);
    cyc(1, 1, 0, 16'h1234, 16'h9999, 3'b000); check("R7 fetch alone", got, 3'b000);
    cyc(0, 0, 1, 16'h7777, 16'h0, 3'b001); check("R7 exec indication", got, 3'b001);
    wr_cfg(1, K_EN | K_TAG, 16'h0, 16'h0);
    wr_cfg(2, K_EN | K_TAG, 16'h0, 16'h0);
    cyc(0, 0, 0, 16'h0, 16'h0, 3'b101); check("R10 lane map A,C", got, 3'b101);
    cyc(0, 0, 0, 16'h0, 16'h0, 3'b111); check("R10 all lanes", got, 3'b111);
    clear_all();
  endtask

  task automatic t_valid_enable();
    wr_cfg(0, K_EN, 16'h3000, 16'h0);
    wr_cfg(1, K_EN, 16'h3000, 16'h0);
    cyc(0, 1, 0, 16'h3000, 16'h0, 0); check("R8 invalid cycle", got, 3'b000);
    cyc(1, 1, 0, 16'h3000, 16'h0, 0); check("R10 shared address", got, 3'b011);
    wr_cfg(1, 7'h00, 16'h3000, 16'h0);
    cyc(1, 1, 0, 16'h3000, 16'h0, 3'b010); check("R9 disabled B", got, 3'b001);
    wr_cfg(3, K_EN, 16'h6000, 16'h0);
    cyc(1, 1, 0, 16'h3000, 16'h0, 0); check("R11 sel 3 keeps A", got, 3'b001);
    cyc(1, 1, 0, 16'h6000, 16'h0, 0); check("R11 sel 3 loads none", got, 3'b000);
    wr_cfg(0, K_EN, 16'h6000, 16'h0);
    cyc(1, 1, 0, 16'h6000, 16'h0, 0); check("R11 new cfg next cycle", got, 3'b001);
    clear_all();
  endtask

  initial begin
    #1 check("R1 in reset", match, 3'b000);
    #24 rst_n = 1'b1;
    t_reset();
    t_addr();
    t_dir();
    t_size_data();
    t_chan_c();
    t_tag();
    t_valid_enable();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule